// File: doc/BRIEF.md
# Four-Channel Byte DMA Engine

This block moves bytes between peripherals and memory for four independent channels, with no processor work per byte. A host programs each channel through a narrow write port. It sets a 16-bit start address, a byte count, a page value that supplies the upper address bits, a mode and a mask bit. A peripheral then raises its request line. The engine answers with a per-channel acknowledge and drives one bus cycle per byte. Each bus cycle carries the full memory address and a matching pair of strobes: a memory strobe plus the opposite I/O strobe.

The engine also handles the end of a programmed run. The current word count counts down on every byte. When it is about to reach zero the engine raises a terminal-count output, and that byte is the last. A peripheral can also cut a run short with an end-of-process input. At the end of a run a channel either reloads its starting values (auto-initialize) or masks itself. A sticky per-channel flag records each terminal count until the host reads the status.

Channels 0 and 1 can be paired for a memory-to-memory copy. The source byte is read through channel 0's address into an internal one-byte holding register. It is then written to channel 1's address. Channel 1's count ends the copy. Page values never advance, so every address sequence wraps inside its own 64 KiB window. A programmed count of 0 means 65536 bytes.

Top module: `dma4_engine`

## Requirements
- R1: After reset every channel is masked, no acknowledge or strobe is active, all status flags read 0, and requests on masked channels get no acknowledge.
- R2: In single mode each acknowledged request moves exactly one byte. The bus cycle drives `mem_addr` = {page, current address}. Mode bit 3 = 0 gives `mem_wr` with `io_rd`; mode bit 3 = 1 gives `mem_rd` with `io_wr`. No strobe is active without an acknowledge.
- R3: After each byte the current address steps by +1 (mode bit 0 = 0) or -1 (mode bit 0 = 1) modulo 65536. The page bits on `mem_addr[23:16]` stay unchanged.
- R4: A count of N moves N bytes. `tc` is high during the bus cycle of the last byte only, and the run then ends.
- R5: In block mode (mode bit 2 = 1) a granted channel moves bytes on consecutive cycles until its run ends, whatever its request line does.
- R6: Among unmasked requests, the lowest channel number wins, and at most one acknowledge is active. A channel in block mode holds the bus until its run ends.
- R7: When `eop_in` is high during a byte's bus cycle, that byte is the last of the run. No status flag is set unless that byte was also the terminal count.
- R8: With auto-initialize (mode bit 1 = 1), the current address and count reload from their base values at the end of a run, and the channel stays unmasked.
- R9: Without auto-initialize, a channel sets its own mask at the end of a run. Each terminal count sets that channel's `stat_tc` bit, and a one-cycle `stat_rd` pulse clears all bits.
- R10: With memory-to-memory enabled, a request on channel 0 starts a copy. Each byte is read at channel 0's address and then written at channel 1's address with the value read, with `dack[0]` held throughout. Channel 1's count ends the copy and sets `stat_tc[1]`.
- R11: A host write selects its target with `cfg_sel`: 0 loads the base and current address, 1 loads the base and current count, 2 loads the mode bits [3:0], 3 loads the page, 4 loads the mask from bit 0, and 5 sets the memory-to-memory enable from bit 0. `cfg_ch` picks the channel for selections 0 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Host write strobe |
| cfg_sel | input | 3 | Host register select |
| cfg_ch | input | 2 | Channel addressed by the write |
| cfg_wdata | input | 16 | Host write data |
| stat_rd | input | 1 | Status read pulse, clears the flags |
| stat_tc | output | 4 | Sticky terminal-count flags |
| dreq | input | 4 | Per-channel transfer requests |
| dack | output | 4 | Per-channel acknowledges |
| eop_in | input | 1 | External end of process |
| mem_addr | output | 24 | Page and address of the bus cycle |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Peripheral read strobe |
| io_wr | output | 1 | Peripheral write strobe |
| mem_rdata | input | 8 | Memory read data for copies |
| mem_wdata | output | 8 | Holding register value for copy writes |
| tc | output | 1 | Terminal count of the current byte |

## Verification
The assertions assume the host does not write a page, mask or mode while that channel owns the bus. Under that assumption the page bits can be held steady across a block run, and status flags rise only from a terminal-count cycle. The stimulus programs each channel fully before raising its request. It drops single-mode requests as soon as it sees the acknowledge. It pulses end of process only inside an acknowledged byte cycle. It never overlaps a status read with a terminal count.

// File: rtl/dma4_pkg.sv
`timescale 1ns/1ps
// dma4_pkg: shared encodings for the four-channel DMA engine.
// Assumes: host select codes fit in three bits.
package dma4_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_IO   = 2'd1,
        ST_MRD  = 2'd2,
        ST_MWR  = 2'd3
    } seq_state_t;

    // Mode bits, LSB first: down, autoinit, block, io_from_mem
    typedef struct packed {
        logic io_from_mem;
        logic block;
        logic autoinit;
        logic down;
    } chan_mode_t;

    localparam logic [2:0] SEL_ADDR   = 3'd0;
    localparam logic [2:0] SEL_COUNT  = 3'd1;
    localparam logic [2:0] SEL_MODE   = 3'd2;
    localparam logic [2:0] SEL_PAGE   = 3'd3;
    localparam logic [2:0] SEL_MASK   = 3'd4;
    localparam logic [2:0] SEL_GLOBAL = 3'd5;

endpackage

// File: rtl/dma4_chan_regs.sv
`timescale 1ns/1ps
// dma4_chan_regs: state of one channel. It holds the base and current
// address and count, the mode, the page latch, the mask and the sticky
// terminal-count flag.
// Assumes: the host does not write this channel while it is moving data
// (a host write takes precedence over stepping). AW, CW and PW <= WW.
module dma4_chan_regs
    import dma4_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int PW = 8,
    parameter int WW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [WW-1:0] wr_data,
    input  logic          step_a,
    input  logic          step_c,
    input  logic          finish,
    input  logic          tc_set,
    input  logic          stat_clr,
    output logic [AW-1:0] cur_addr,
    output logic [PW-1:0] page,
    output logic          cnt_last,
    output logic          blk,
    output logic          io_from_mem,
    output logic          masked,
    output logic          tc_flag
);

    logic [AW-1:0] base_addr;
    logic [CW-1:0] base_cnt;
    logic [CW-1:0] cur_cnt;
    chan_mode_t    mode;

    assign cnt_last    = (cur_cnt == CW'(1));
    assign blk         = mode.block;
    assign io_from_mem = mode.io_from_mem;

    // Purpose: host programming, per-byte stepping and end-of-run handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            cur_addr  <= '0;
            base_cnt  <= '0;
            cur_cnt   <= '0;
            mode      <= '0;
            page      <= '0;
            masked    <= 1'b1;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_ADDR:  begin base_addr <= wr_data[AW-1:0]; cur_addr <= wr_data[AW-1:0]; end
                SEL_COUNT: begin base_cnt  <= wr_data[CW-1:0]; cur_cnt  <= wr_data[CW-1:0]; end
                SEL_MODE:  mode   <= chan_mode_t'(wr_data[3:0]);
                SEL_PAGE:  page   <= wr_data[PW-1:0];
                SEL_MASK:  masked <= wr_data[0];
                default:   ;
            endcase
        end else begin
            if (step_a)
                cur_addr <= mode.down ? cur_addr - AW'(1) : cur_addr + AW'(1);
            if (step_c)
                cur_cnt <= cur_cnt - CW'(1);
            if (finish) begin
                if (mode.autoinit) begin
                    cur_addr <= base_addr;
                    cur_cnt  <= base_cnt;
                end else begin
                    masked <= 1'b1;
                end
            end
        end
    end

    // Purpose: sticky terminal-count flag; a new terminal count wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        tc_flag <= 1'b0;
        else if (tc_set)   tc_flag <= 1'b1;
        else if (stat_clr) tc_flag <= 1'b0;
    end

endmodule

// File: rtl/dma4_prio.sv
`timescale 1ns/1ps
// dma4_prio: fixed-priority picker; the lowest index wins.
// Assumes: nothing about the request pattern. The output is one-hot or zero.
module dma4_prio #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);

    // Purpose: scan from the highest index down so that the lowest set bit remains.
    always_comb begin
        gnt = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dma4_seq.sv
`timescale 1ns/1ps
// dma4_seq: transfer sequencer. It grants a channel and runs one-cycle I/O
// byte cycles, or paired read/write cycles for memory-to-memory copies.
// It issues the per-channel step, finish and terminal-count controls.
// Assumes: N >= 2 (the copy uses channels 0 and 1).
module dma4_seq
    import dma4_pkg::*;
#(
    parameter int N    = 4,
    parameter int DW   = 8,
    parameter int IDXW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    pend,
    input  logic            m2m_en,
    input  logic            eop_in,
    input  logic [N-1:0]    cnt_last,
    input  logic [N-1:0]    blk_v,
    input  logic [DW-1:0]   mem_rdata,
    output seq_state_t      state,
    output logic [IDXW-1:0] act,
    output logic [DW-1:0]   hold,
    output logic [N-1:0]    step_a,
    output logic [N-1:0]    step_c,
    output logic [N-1:0]    fin,
    output logic [N-1:0]    tc_set
);

    logic [N-1:0]    gnt;
    logic [IDXW-1:0] gidx;
    seq_state_t      nxt;
    logic [IDXW-1:0] nxt_act;

    dma4_prio #(.N(N)) u_prio (.req(pend), .gnt(gnt));

    // Purpose: convert the one-hot grant to a channel index.
    always_comb begin
        gidx = '0;
        for (int i = 0; i < N; i++)
            if (gnt[i]) gidx = IDXW'(i);
    end

    // Purpose: next state and per-channel controls for the current cycle.
    always_comb begin
        nxt     = state;
        nxt_act = act;
        step_a  = '0;
        step_c  = '0;
        fin     = '0;
        tc_set  = '0;
        case (state)
            ST_IDLE: begin
                if (m2m_en && pend[0]) begin
                    nxt     = ST_MRD;
                    nxt_act = '0;
                end else if (|pend) begin
                    nxt     = ST_IO;
                    nxt_act = gidx;
                end
            end
            ST_IO: begin
                step_a[act] = 1'b1;
                step_c[act] = 1'b1;
                if (cnt_last[act] || eop_in) begin
                    fin[act]    = 1'b1;
                    tc_set[act] = cnt_last[act];
                    nxt         = ST_IDLE;
                end else if (!blk_v[act]) begin
                    nxt = ST_IDLE;
                end
            end
            ST_MRD: begin
                step_a[0] = 1'b1;
                nxt       = ST_MWR;
            end
            ST_MWR: begin
                step_a[1] = 1'b1;
                step_c[1] = 1'b1;
                if (cnt_last[1] || eop_in) begin
                    fin[0]    = 1'b1;
                    fin[1]    = 1'b1;
                    tc_set[1] = cnt_last[1];
                    nxt       = ST_IDLE;
                end else begin
                    nxt = ST_MRD;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Purpose: sequencer registers and the one-byte holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            act   <= '0;
            hold  <= '0;
        end else begin
            state <= nxt;
            act   <= nxt_act;
            if (state == ST_MRD)
                hold <= mem_rdata;
        end
    end

endmodule

// File: rtl/dma4_engine.sv
`timescale 1ns/1ps
// dma4_engine: four-channel byte DMA engine (top).
// It owns the host write decode, the per-channel register sets, the
// sequencer and the bus-cycle decode.
// Assumes: one byte per bus cycle, memory answers reads in the same cycle,
// and the host does not reprogram a channel that owns the bus.
module dma4_engine
    import dma4_pkg::*;
#(
    parameter int N_CH = 4,
    parameter int AW   = 16,
    parameter int CW   = 16,
    parameter int PW   = 8,
    parameter int DW   = 8,
    parameter int WW   = 16,
    localparam int IDXW = $clog2(N_CH),
    localparam int MAW  = PW + AW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [2:0]      cfg_sel,
    input  logic [IDXW-1:0] cfg_ch,
    input  logic [WW-1:0]   cfg_wdata,
    input  logic            stat_rd,
    output logic [N_CH-1:0] stat_tc,
    input  logic [N_CH-1:0] dreq,
    output logic [N_CH-1:0] dack,
    input  logic            eop_in,
    output logic [MAW-1:0]  mem_addr,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            io_rd,
    output logic            io_wr,
    input  logic [DW-1:0]   mem_rdata,
    output logic [DW-1:0]   mem_wdata,
    output logic            tc
);

    logic [AW-1:0]   cur_a [N_CH];
    logic [PW-1:0]   pg    [N_CH];
    logic [N_CH-1:0] cnt_last, blk_v, typ_v, masked;
    logic [N_CH-1:0] step_a, step_c, fin, tc_set;
    logic            m2m_en;
    seq_state_t      state;
    logic [IDXW-1:0] act;
    logic [DW-1:0]   hold;

    // Purpose: memory-to-memory enable from the global select.
    always_ff @(posedge clk) begin
        if (!rst_n)
            m2m_en <= 1'b0;
        else if (cfg_we && cfg_sel == SEL_GLOBAL)
            m2m_en <= cfg_wdata[0];
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        dma4_chan_regs #(.AW(AW), .CW(CW), .PW(PW), .WW(WW)) u_regs (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (cfg_we && cfg_ch == IDXW'(g) && cfg_sel != SEL_GLOBAL),
            .wr_sel      (cfg_sel),
            .wr_data     (cfg_wdata),
            .step_a      (step_a[g]),
            .step_c      (step_c[g]),
            .finish      (fin[g]),
            .tc_set      (tc_set[g]),
            .stat_clr    (stat_rd),
            .cur_addr    (cur_a[g]),
            .page        (pg[g]),
            .cnt_last    (cnt_last[g]),
            .blk         (blk_v[g]),
            .io_from_mem (typ_v[g]),
            .masked      (masked[g]),
            .tc_flag     (stat_tc[g])
        );
    end

    dma4_seq #(.N(N_CH), .DW(DW), .IDXW(IDXW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (dreq & ~masked),
        .m2m_en    (m2m_en),
        .eop_in    (eop_in),
        .cnt_last  (cnt_last),
        .blk_v     (blk_v),
        .mem_rdata (mem_rdata),
        .state     (state),
        .act       (act),
        .hold      (hold),
        .step_a    (step_a),
        .step_c    (step_c),
        .fin       (fin),
        .tc_set    (tc_set)
    );

    assign mem_wdata = hold;

    // Purpose: drive acknowledge, address, strobes and terminal count for the cycle.
    always_comb begin
        dack     = '0;
        mem_addr = '0;
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        io_rd    = 1'b0;
        io_wr    = 1'b0;
        tc       = 1'b0;
        case (state)
            ST_IO: begin
                dack[act] = 1'b1;
                mem_addr  = {pg[act], cur_a[act]};
                if (typ_v[act]) begin
                    mem_rd = 1'b1;
                    io_wr  = 1'b1;
                end else begin
                    mem_wr = 1'b1;
                    io_rd  = 1'b1;
                end
                tc = cnt_last[act];
            end
            ST_MRD: begin
                dack[0]  = 1'b1;
                mem_addr = {pg[0], cur_a[0]};
                mem_rd   = 1'b1;
            end
            ST_MWR: begin
                dack[0]  = 1'b1;
                mem_addr = {pg[1], cur_a[1]};
                mem_wr   = 1'b1;
                tc       = cnt_last[1];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dma4_engine_chk.sv
`timescale 1ns/1ps
// dma4_engine_chk: temporal checks on the DMA engine's bus outputs.
// Assumes: pages are not rewritten while a channel owns the bus.
module dma4_engine_chk #(
    parameter int N_CH = 4,
    parameter int PW   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_CH-1:0] dack,
    input logic            mem_rd,
    input logic            mem_wr,
    input logic            io_rd,
    input logic            io_wr,
    input logic            tc,
    input logic [PW-1:0]   pg_bits,
    input logic [N_CH-1:0] stat_tc
);

    // R6
    one_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack));

    // R2
    strobe_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr || io_rd || io_wr) |-> (dack != '0));

    // R2
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R4
    tc_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> ((dack != '0) && (mem_rd || mem_wr)));

    // R10
    m2m_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !io_rd) |-> $past(mem_rd && !io_wr));

    // R3
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_rd || io_wr) && $past(io_rd || io_wr) && dack == $past(dack))
        |-> $stable(pg_bits));

    // R9
    stat_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_tc & ~$past(stat_tc)) != '0) |-> $past(tc));

endmodule

bind dma4_engine dma4_engine_chk #(.N_CH(N_CH), .PW(PW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .dack    (dack),
    .mem_rd  (mem_rd),
    .mem_wr  (mem_wr),
    .io_rd   (io_rd),
    .io_wr   (io_wr),
    .tc      (tc),
    .pg_bits (mem_addr[PW+AW-1:AW]),
    .stat_tc (stat_tc)
);

// File: tb/dma4_engine_bench.sv
`timescale 1ns/1ps
// dma4_engine_bench: behavioural reference model compared on every cycle,
// plus directed scenarios with named checks.
module dma4_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [1:0]  cfg_ch = '0;
    logic [15:0] cfg_wdata = '0;
    logic        stat_rd = 1'b0;
    logic [3:0]  stat_tc;
    logic [3:0]  dreq = '0;
    logic [3:0]  dack;
    logic        eop_in = 1'b0;
    logic [23:0] mem_addr;
    logic        mem_rd, mem_wr, io_rd, io_wr, tc;
    logic [7:0]  mem_rdata, mem_wdata;

    int checks = 0;
    int fails  = 0;
    bit chk_on = 0;

    always #2 clk = ~clk;

    dma4_engine u_dma4_engine (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_ch(cfg_ch), .cfg_wdata(cfg_wdata), .stat_rd(stat_rd),
        .stat_tc(stat_tc), .dreq(dreq), .dack(dack), .eop_in(eop_in),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .io_rd(io_rd), .io_wr(io_wr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .tc(tc)
    );

    // Environment memory, 256 bytes indexed by the low address byte
    logic [7:0] mem [256];
    initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] actv, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, actv, expv);
        end
    endtask

    // ---------------- reference model ----------------
    int          m_state, m_ch;
    logic [15:0] m_ba[4], m_ca[4], m_bc[4], m_cc[4];
    logic [7:0]  m_pg[4];
    logic [3:0]  m_md[4];
    logic [3:0]  m_msk, m_st;
    logic        m_m2m;
    logic [7:0]  m_hold;

    task automatic m_step(input int c);
        m_ca[c] = m_md[c][0] ? m_ca[c] - 16'd1 : m_ca[c] + 16'd1;
    endtask

    task automatic m_end(input int c);
        if (m_md[c][1]) begin
            m_ca[c] = m_ba[c];
            m_cc[c] = m_bc[c];
        end else begin
            m_msk[c] = 1'b1;
        end
    endtask

    always @(posedge clk) begin
        logic [3:0] pend, setb;
        logic       last;
        int         sel;
        if (!rst_n) begin
            m_state = 0; m_ch = 0; m_msk = 4'hF; m_st = 0; m_m2m = 0; m_hold = 0;
            for (int i = 0; i < 4; i++) begin
                m_ba[i] = 0; m_ca[i] = 0; m_bc[i] = 0; m_cc[i] = 0; m_pg[i] = 0; m_md[i] = 0;
            end
        end else begin
            setb = 0;
            if (cfg_we) begin
                case (cfg_sel)
                    3'd0: begin m_ba[cfg_ch] = cfg_wdata; m_ca[cfg_ch] = cfg_wdata; end
                    3'd1: begin m_bc[cfg_ch] = cfg_wdata; m_cc[cfg_ch] = cfg_wdata; end
                    3'd2: m_md[cfg_ch] = cfg_wdata[3:0];
                    3'd3: m_pg[cfg_ch] = cfg_wdata[7:0];
                    3'd4: m_msk[cfg_ch] = cfg_wdata[0];
                    3'd5: m_m2m = cfg_wdata[0];
                    default: ;
                endcase
            end
            case (m_state)
                0: begin
                    pend = dreq & ~m_msk;
                    sel = -1;
                    for (int i = 3; i >= 0; i--) if (pend[i]) sel = i;
                    if (m_m2m && pend[0]) begin m_state = 2; m_ch = 0; end
                    else if (sel >= 0) begin m_state = 1; m_ch = sel; end
                end
                1: begin
                    last = (m_cc[m_ch] == 16'd1);
                    m_step(m_ch);
                    m_cc[m_ch] = m_cc[m_ch] - 16'd1;
                    if (last || eop_in) begin
                        m_end(m_ch);
                        if (last) setb[m_ch] = 1'b1;
                        m_state = 0;
                    end else if (!m_md[m_ch][2]) begin
                        m_state = 0;
                    end
                end
                2: begin
                    m_hold = mem[m_ca[0][7:0]];
                    m_step(0);
                    m_state = 3;
                end
                default: begin
                    last = (m_cc[1] == 16'd1);
                    m_step(1);
                    m_cc[1] = m_cc[1] - 16'd1;
                    if (last || eop_in) begin
                        m_end(0);
                        m_end(1);
                        if (last) setb[1] = 1'b1;
                        m_state = 0;
                    end else begin
                        m_state = 2;
                    end
                end
            endcase
            m_st = (stat_rd ? 4'h0 : m_st) | setb;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        logic [3:0]  ed;
        logic [23:0] ea;
        logic [3:0]  es;
        logic        et;
        if (chk_on) begin
            ed = 0; ea = 0; es = 0; et = 0;
            case (m_state)
                1: begin
                    ed[m_ch] = 1'b1;
                    ea = {m_pg[m_ch], m_ca[m_ch]};
                    es = m_md[m_ch][3] ? 4'b1001 : 4'b0110;
                    et = (m_cc[m_ch] == 16'd1);
                end
                2: begin ed[0] = 1'b1; ea = {m_pg[0], m_ca[0]}; es = 4'b1000; end
                3: begin
                    ed[0] = 1'b1; ea = {m_pg[1], m_ca[1]}; es = 4'b0100;
                    et = (m_cc[1] == 16'd1);
                end
                default: ;
            endcase
            chk(dack == ed, "R6", "dack", dack, ed);
            chk(mem_addr == ea, "R3", "mem_addr", mem_addr, ea);
            chk({mem_rd, mem_wr, io_rd, io_wr} == es, "R2", "strobes",
                {mem_rd, mem_wr, io_rd, io_wr}, es);
            chk(tc == et, "R4", "tc", tc, et);
            chk(stat_tc == m_st, "R9", "stat_tc", stat_tc, m_st);
            if (m_state == 3) chk(mem_wdata == m_hold, "R10", "mem_wdata", mem_wdata, m_hold);
        end
    end

    // ---------------- stimulus helpers ----------------
    int          w_cnt[4], w_first, w_fc[4], w_lc[4];
    logic [23:0] w_last[4];

    task automatic cfg(input logic [2:0] s, input int c, input logic [15:0] d);
        cfg_we = 1; cfg_sel = s; cfg_ch = 2'(c); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic prog(input int c, input logic [15:0] a, input logic [15:0] n,
                        input logic [3:0] md, input logic [7:0] p);
        cfg(3'd0, c, a);
        cfg(3'd1, c, n);
        cfg(3'd2, c, {12'd0, md});
        cfg(3'd3, c, {8'd0, p});
        cfg(3'd4, c, 16'd0);
    endtask

    task automatic window(input int n, input logic [3:0] drop, input int eop_ch, input int eop_k);
        for (int i = 0; i < 4; i++) begin w_cnt[i] = 0; w_last[i] = 0; w_fc[i] = -1; w_lc[i] = -1; end
        w_first = -1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            eop_in = 0;
            for (int i = 0; i < 4; i++) begin
                if (dack[i]) begin
                    w_cnt[i]++;
                    w_last[i] = mem_addr;
                    if (w_fc[i] < 0) w_fc[i] = k;
                    w_lc[i] = k;
                    if (w_first < 0) w_first = i;
                    if (drop[i]) dreq[i] = 0;
                    if (i == eop_ch && w_cnt[i] == eop_k) eop_in = 1;
                end
            end
        end
        eop_in = 0;
    endtask

    task automatic one_req(input int c);
        dreq[c] = 1;
        window(6, 4'b0001 << c, -1, 0);
        dreq[c] = 0;
    endtask

    task automatic read_status();
        stat_rd = 1;
        @(negedge clk);
        stat_rd = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: all requirements, actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(dack == 0, "R1", "dack in reset", dack, 0);
        chk({mem_rd, mem_wr, io_rd, io_wr, tc} == 0, "R1", "strobes in reset",
            {mem_rd, mem_wr, io_rd, io_wr, tc}, 0);
        chk(stat_tc == 0, "R1", "stat in reset", stat_tc, 0);
        rst_n = 1;
        @(negedge clk);
        chk_on = 1;
        dreq = 4'hF;
        window(5, 4'h0, -1, 0);
        dreq = 0;
        chk(w_first == -1, "R1", "ack while masked", w_first, -1);

        // R2, R11: single mode, count 3, inc, peripheral to memory
        prog(2, 16'h1000, 16'd3, 4'b0000, 8'h12);
        one_req(2);
        chk(w_cnt[2] == 1 && w_last[2] == 24'h121000, "R2", "first single byte", w_last[2], 24'h121000);
        one_req(2);
        chk(w_cnt[2] == 1 && w_last[2] == 24'h121001, "R2", "second single byte", w_last[2], 24'h121001);
        one_req(2);
        chk(w_last[2] == 24'h121002, "R4", "last byte address", w_last[2], 24'h121002);
        chk(stat_tc[2] == 1'b1, "R4", "terminal count flag", stat_tc, 4'h4);
        one_req(2);
        chk(w_cnt[2] == 0, "R9", "masked after run", w_cnt[2], 0);
        read_status();
        chk(stat_tc == 0, "R9", "status cleared by read", stat_tc, 0);

        // R3, R5: block, decrement, wraps inside the page window
        prog(1, 16'h0001, 16'd3, 4'b1101, 8'h05);
        dreq[1] = 1;
        window(10, 4'h0, -1, 0);
        dreq[1] = 0;
        chk(w_cnt[1] == 3, "R5", "block byte count", w_cnt[1], 3);
        chk(w_lc[1] - w_fc[1] == 2, "R5", "consecutive cycles", w_lc[1] - w_fc[1], 2);
        chk(w_last[1] == 24'h05FFFF, "R3", "wrapped address", w_last[1], 24'h05FFFF);
        read_status();

        // R6: channel 0 (block, 2 bytes) beats channel 3 (single)
        prog(0, 16'h0300, 16'd2, 4'b0100, 8'h00);
        prog(3, 16'h0400, 16'd5, 4'b0000, 8'h00);
        dreq = 4'b1001;
        window(12, 4'b1000, -1, 0);
        dreq = 0;
        chk(w_first == 0, "R6", "first grant", w_first, 0);
        chk(w_cnt[0] == 2 && w_fc[3] > w_lc[0], "R6", "block holds bus", w_fc[3], w_lc[0] + 1);
        chk(w_cnt[3] == 1, "R2", "one byte for one request", w_cnt[3], 1);
        read_status();

        // R7: end of process on the 4th byte of a 10-byte block run
        prog(2, 16'h2000, 16'd10, 4'b0100, 8'h00);
        dreq[2] = 1;
        window(16, 4'h0, 2, 4);
        dreq[2] = 0;
        chk(w_cnt[2] == 4, "R7", "bytes before end of process", w_cnt[2], 4);
        chk(stat_tc[2] == 1'b0, "R7", "no flag without tc", stat_tc, 0);
        one_req(2);
        chk(w_cnt[2] == 0, "R9", "masked after end of process", w_cnt[2], 0);

        // R8: auto-initialize, single mode, count 2
        prog(3, 16'h0200, 16'd2, 4'b0010, 8'h33);
        one_req(3);
        one_req(3);
        chk(w_last[3] == 24'h330201, "R8", "second byte", w_last[3], 24'h330201);
        one_req(3);
        chk(w_cnt[3] == 1 && w_last[3] == 24'h330200, "R8", "reloaded address", w_last[3], 24'h330200);
        chk(stat_tc[3] == 1'b1, "R8", "flag with autoinit", stat_tc, 4'h8);
        read_status();

        // R10: memory-to-memory copy of 4 bytes, 0x10 -> 0x40
        prog(0, 16'h0010, 16'd1, 4'b0000, 8'h00);
        prog(1, 16'h0040, 16'd4, 4'b0000, 8'h00);
        cfg(3'd4, 1, 16'd1);
        cfg(3'd5, 0, 16'd1);
        dreq[0] = 1;
        window(12, 4'b0001, -1, 0);
        dreq[0] = 0;
        chk(w_cnt[0] == 8, "R10", "copy cycles", w_cnt[0], 8);
        for (int i = 0; i < 4; i++)
            chk(mem[8'h40 + i] == (8'(8'h10 + i) ^ 8'hA5), "R10", "copied byte",
                mem[8'h40 + i], 8'(8'h10 + i) ^ 8'hA5);
        chk(stat_tc[1] == 1'b1, "R10", "channel 1 flag", stat_tc, 4'h2);
        cfg(3'd5, 0, 16'd0);
        read_status();

        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule